// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns the refresh duty for a 512-row asynchronous DRAM that is run from a synchronous system clock. When reset is released it keeps the memory completely idle for a programmable pause. It then runs a fixed burst of warm-up refresh cycles back to back, without asking for the bus, and only after that raises `ready`. No normal access grant can pass through the block before `ready` is high.

In normal operation an interval timer adds one unit of refresh debt each period. The period is derived from the retention window, rounded down, so that every row is refreshed in time. While debt is owed and the strobes are idle, the block raises a request to the access arbiter. When the arbiter grants it, the block drives a CAS-before-RAS refresh on both byte-lane CAS strobes. The arbiter may postpone refreshes. Once the debt reaches a parameterised limit, the block raises an urgent flag, blocks access grants and starts the refresh without waiting for a grant. Throughout a refresh cycle the block tells the data path to leave both byte lanes floating. Every time limit is a parameter counted in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: For the first PAUSE_CYC clock cycles after reset release, `ras_n`, `lcas_n` and `ucas_n` stay high and `ready` stays low.
- R2: After the pause, exactly WARMUP_CNT refresh cycles run with no grant needed, spaced LEAD_CYC+RAS_LOW_CYC+RAS_PRE_CYC+1 cycles from one RAS fall to the next. `ready` rises when the last of them ends and stays high until reset.
- R3: In every refresh cycle, CAS (both lanes, always equal) falls while RAS is high and stays low for exactly LEAD_CYC cycles before RAS falls.
- R4: RAS stays low for exactly RAS_LOW_CYC cycles. CAS stays low for the first HOLD_CYC of those cycles and is high again before RAS rises.
- R5: RAS stays high for at least RAS_PRE_CYC cycles between refresh pulses, and consecutive RAS falls are at least RAS_LOW_CYC+RAS_PRE_CYC cycles apart.
- R6: `lane_hiz` is high in every cycle in which any strobe is low.
- R7: Once `ready` is high, refresh debt equals the number of interval ticks minus the number of refreshes started. Ticks arrive every INTERVAL_CYC = RETENTION_CYC/(ROWS+MAX_DEBT+1) cycles, rounded down, counting from the rise of `ready`. `ref_req` is high exactly when the block is ready, the strobes are idle (`lane_hiz` low) and the debt is non-zero.
- R8: A normal refresh starts on the edge after a cycle in which either `ref_req` and `ref_gnt` were both high, or `ref_urgent` was high. It starts at no other time.
- R9: `ref_urgent` is high exactly when `ready` is high and the debt is at least MAX_DEBT.
- R10: `acc_gnt_o` equals `acc_gnt_i` AND `ready` AND NOT `lane_hiz` AND NOT `ref_urgent` AND NOT (`ref_req` AND `ref_gnt`).
- R11: After `ready` rises, every window of RETENTION_CYC cycles contains at least ROWS refresh RAS pulses, whatever the grant pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grant for a refresh request |
| acc_gnt_i | input | 1 | Arbiter grant for a normal access, before gating |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_urgent | output | 1 | Debt at its limit; a refresh will be forced |
| ready | output | 1 | Power-up sequence complete |
| acc_gnt_o | output | 1 | Gated normal-access grant |
| lane_hiz | output | 1 | Both data byte lanes must float |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-lane column strobe, active low |
| ucas_n | output | 1 | Upper-lane column strobe, active low |

## Verification
The bench goes after the point where power-up hands over to normal operation. A design that starts early, runs too few or too many warm-up cycles, or raises `ready` one cycle late is caught by exact counts of RAS pulses and samples. Within each refresh it measures CAS lead, CAS hold and RAS width. A design with the strobe order reversed, or with a state shortened by one cycle, fails these exact counts. A long stretch with the grant held low pushes the debt to its limit. A design that never forces a refresh, or that forces it at the wrong debt, shows up in the debt model and in the sliding retention-window count. That window count also catches an interval rounded the wrong way.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE = 3'd0,  // power-up hold-off
    ST_IDLE  = 3'd1,  // strobes released, waiting for work
    ST_LEAD  = 3'd2,  // CAS low, RAS high
    ST_HOLD  = 3'd3,  // CAS and RAS low
    ST_LOW   = 3'd4,  // RAS low, CAS back high
    ST_PRE   = 3'd5   // RAS precharge
  } rfs_state_e;

endpackage

// File: rtl/rfs_interval.sv
module rfs_interval #(
  parameter int INTERVAL_CYC = 3868
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = $clog2(INTERVAL_CYC + 1);
  localparam logic [W-1:0] RELOAD = W'(INTERVAL_CYC - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign tick   = run && (cnt_q == '0);
  assign cnt_en = run || (cnt_q != RELOAD);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = RELOAD;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RELOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfs_debt.sv
module rfs_debt #(
  parameter int MAX_DEBT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic owed,
  output logic at_limit
);
  localparam int DW = $clog2(MAX_DEBT + 1);
  localparam logic [DW-1:0] LIMIT = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q, debt_d;
  logic          debt_en;

  assign owed     = (debt_q != '0);
  assign at_limit = (debt_q >= LIMIT);
  assign debt_en  = inc ^ dec;

  always_comb begin
    debt_d = debt_q;
    if (inc && !dec && !at_limit) debt_d = debt_q + 1'b1;
    else if (dec && !inc && owed)  debt_d = debt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       debt_q <= '0;
    else if (debt_en) debt_q <= debt_d;
  end
endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
  import rfs_pkg::*;
#(
  parameter int PAUSE_CYC   = 50000,
  parameter int WARMUP_CNT  = 8,
  parameter int LEAD_CYC    = 2,
  parameter int HOLD_CYC    = 3,
  parameter int RAS_LOW_CYC = 8,
  parameter int RAS_PRE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owed,
  input  logic force_go,
  input  logic gnt,
  output logic ready,
  output logic idle,
  output logic busy,
  output logic go_normal,
  output logic ras_n,
  output logic cas_n
);
  localparam int TW = $clog2(PAUSE_CYC + LEAD_CYC + RAS_LOW_CYC + RAS_PRE_CYC + 1);
  localparam int WW = $clog2(WARMUP_CNT + 1);

  rfs_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [WW-1:0] warm_q, warm_d;
  logic          rdy_q, rdy_d;
  logic          done;

  assign done = (tmr_q == '0);

  always_comb begin
    st_d      = st_q;
    tmr_d     = tmr_q;
    warm_d    = warm_q;
    rdy_d     = rdy_q;
    go_normal = 1'b0;
    unique case (st_q)
      ST_PAUSE: begin
        if (done) st_d = ST_IDLE;
        else      tmr_d = tmr_q - 1'b1;
      end
      ST_IDLE: begin
        if (warm_q != '0) begin
          st_d   = ST_LEAD;
          tmr_d  = TW'(LEAD_CYC - 1);
          warm_d = warm_q - 1'b1;
        end else if (rdy_q && owed && (gnt || force_go)) begin
          st_d      = ST_LEAD;
          tmr_d     = TW'(LEAD_CYC - 1);
          go_normal = 1'b1;
        end
      end
      ST_LEAD: begin
        if (done) begin
          st_d  = ST_HOLD;
          tmr_d = TW'(HOLD_CYC - 1);
        end else tmr_d = tmr_q - 1'b1;
      end
      ST_HOLD: begin
        if (done) begin
          st_d  = ST_LOW;
          tmr_d = TW'(RAS_LOW_CYC - HOLD_CYC - 1);
        end else tmr_d = tmr_q - 1'b1;
      end
      ST_LOW: begin
        if (done) begin
          st_d  = ST_PRE;
          tmr_d = TW'(RAS_PRE_CYC - 1);
        end else tmr_d = tmr_q - 1'b1;
      end
      ST_PRE: begin
        if (done) begin
          st_d = ST_IDLE;
          if (warm_q == '0) rdy_d = 1'b1;
        end else tmr_d = tmr_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PAUSE;
      tmr_q  <= TW'(PAUSE_CYC - 1);
      warm_q <= WW'(WARMUP_CNT);
      rdy_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      warm_q <= warm_d;
      rdy_q  <= rdy_d;
    end
  end

  assign ready = rdy_q;
  assign idle  = (st_q == ST_IDLE);
  assign busy  = (st_q == ST_LEAD) || (st_q == ST_HOLD) ||
                 (st_q == ST_LOW)  || (st_q == ST_PRE);
  assign ras_n = !((st_q == ST_HOLD) || (st_q == ST_LOW));
  assign cas_n = !((st_q == ST_LEAD) || (st_q == ST_HOLD));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PAUSE_CYC     = 50000,
  parameter int RETENTION_CYC = 2000000,
  parameter int ROWS          = 512,
  parameter int WARMUP_CNT    = 8,
  parameter int MAX_DEBT      = 4,
  parameter int LEAD_CYC      = 2,
  parameter int HOLD_CYC      = 3,
  parameter int RAS_LOW_CYC   = 8,
  parameter int RAS_PRE_CYC   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic acc_gnt_i,
  output logic ref_req,
  output logic ref_urgent,
  output logic ready,
  output logic acc_gnt_o,
  output logic lane_hiz,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n
);
  // rounded down, with room for the postponed refreshes, so no row is late
  localparam int INTERVAL_CYC = RETENTION_CYC / (ROWS + MAX_DEBT + 1);
  localparam int LANES = 2;

  logic tick, owed, at_limit, idle, busy, go_normal, cas_n;
  logic [LANES-1:0] cas_lane_n;

  rfs_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_ivl (
    .clk(clk), .rst_n(rst_n), .run(ready), .tick(tick)
  );

  rfs_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk(clk), .rst_n(rst_n), .inc(tick), .dec(go_normal),
    .owed(owed), .at_limit(at_limit)
  );

  rfs_seq #(
    .PAUSE_CYC(PAUSE_CYC), .WARMUP_CNT(WARMUP_CNT), .LEAD_CYC(LEAD_CYC),
    .HOLD_CYC(HOLD_CYC), .RAS_LOW_CYC(RAS_LOW_CYC), .RAS_PRE_CYC(RAS_PRE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .owed(owed), .force_go(at_limit), .gnt(ref_gnt),
    .ready(ready), .idle(idle), .busy(busy), .go_normal(go_normal),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_lane_n[g] = cas_n;
  end

  assign lcas_n     = cas_lane_n[0];
  assign ucas_n     = cas_lane_n[1];
  assign lane_hiz   = busy;
  assign ref_req    = ready && idle && owed;
  assign ref_urgent = ready && at_limit;
  assign acc_gnt_o  = acc_gnt_i && ready && idle && !ref_urgent && !(ref_req && ref_gnt);
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int PAUSE_CYC = 50000
) (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic acc_gnt_i,
  input logic ref_req,
  input logic ref_urgent,
  input logic ready,
  input logic acc_gnt_o,
  input logic lane_hiz,
  input logic ras_n,
  input logic lcas_n,
  input logic ucas_n
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  logic [PW-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != PW'(PAUSE_CYC)) since_rst <= since_rst + 1'b1;
  end

  a_r1_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < PW'(PAUSE_CYC)) |-> (ras_n && lcas_n && ucas_n && !ready));

  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  a_r3_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
    lcas_n == ucas_n);

  a_r3_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !lcas_n);

  a_r4_cas_up_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lcas_n);

  a_r6_lanes_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !lcas_n) |-> lane_hiz);

  a_r8_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lcas_n) && $past(ready)) |-> ($past(ref_req && ref_gnt) || $past(ref_urgent)));

  a_r9_urgent_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ready);

  a_r10_access_gate: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt_o |-> (acc_gnt_i && ready && !lane_hiz && !ref_urgent));
endmodule

bind dram_refresh_sched rfs_checker #(.PAUSE_CYC(PAUSE_CYC)) u_rfs_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .acc_gnt_i(acc_gnt_i),
  .ref_req(ref_req), .ref_urgent(ref_urgent), .ready(ready),
  .acc_gnt_o(acc_gnt_o), .lane_hiz(lane_hiz), .ras_n(ras_n),
  .lcas_n(lcas_n), .ucas_n(ucas_n)
);

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/100ps
module dram_refresh_sched_test;
  localparam int PAUSE   = 200;
  localparam int RET     = 12408;
  localparam int ROWS    = 512;
  localparam int WARM    = 8;
  localparam int MAXD    = 4;
  localparam int LEAD    = 2;
  localparam int HOLD    = 3;
  localparam int RLOW    = 8;
  localparam int RPRE    = 6;

  logic clk, rst_n, ref_gnt, acc_gnt_i;
  logic ref_req, ref_urgent, ready, acc_gnt_o, lane_hiz, ras_n, lcas_n, ucas_n;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .RETENTION_CYC(RET), .ROWS(ROWS), .WARMUP_CNT(WARM),
    .MAX_DEBT(MAXD), .LEAD_CYC(LEAD), .HOLD_CYC(HOLD), .RAS_LOW_CYC(RLOW),
    .RAS_PRE_CYC(RPRE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .acc_gnt_i(acc_gnt_i),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .ready(ready),
    .acc_gnt_o(acc_gnt_o), .lane_hiz(lane_hiz), .ras_n(ras_n),
    .lcas_n(lcas_n), .ucas_n(ucas_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  function automatic int exp_interval();
    return RET / (ROWS + MAXD + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at sample %0d", req, act, exp, cyc);
    end
  endtask

  // monitor state
  longint cyc = 0;
  longint rdy_at = -1, last_fall = -1, first_cas = -1;
  int lead_n = 0, rlo_n = 0, cil_n = 0, rhi_n = 0, n_falls = 0, n_rises = 0;
  int starts = 0;
  bit p_ras = 1, p_cas = 1, p_rdy = 0, p_urg = 0, p_req = 0, p_gnt = 0;
  bit saw_urgent = 0;
  longint ts[$];

  task automatic monitor();
    longint ticks, debt;
    cyc++;
    chk(lcas_n == ucas_n, "R3 lanes", lcas_n, ucas_n);
    if (cyc <= PAUSE) chk(ras_n && lcas_n && !ready, "R1 pause", {ras_n, lcas_n, ready}, 3'b110);
    if (!lcas_n && first_cas < 0) begin
      first_cas = cyc;
      chk(cyc > PAUSE, "R1 first strobe", cyc, PAUSE + 1);
    end
    if (ras_n && !lcas_n) lead_n++;
    if (p_cas && !lcas_n && p_rdy) begin
      starts++;
      chk(p_urg || (p_req && p_gnt), "R8 start cause", {p_urg, p_req, p_gnt}, 1);
    end
    if (p_rdy && !lane_hiz && p_req && (p_gnt || p_urg))
      chk(1'b0, "R8 missed start", 0, 1);
    if (p_ras && !ras_n) begin
      chk(!lcas_n, "R3 cas before ras", lcas_n, 0);
      chk(lead_n == LEAD, "R3 cas lead", lead_n, LEAD);
      if (n_falls > 0) begin
        chk(rhi_n >= RPRE, "R5 precharge", rhi_n, RPRE);
        chk(cyc - last_fall >= RLOW + RPRE, "R5 cycle", cyc - last_fall, RLOW + RPRE);
        if (n_falls < WARM)
          chk(cyc - last_fall == LEAD + RLOW + RPRE + 1, "R2 warm spacing",
              cyc - last_fall, LEAD + RLOW + RPRE + 1);
      end
      last_fall = cyc; n_falls++; rlo_n = 0; cil_n = 0;
      if (p_rdy) ts.push_back(cyc);
    end
    if (!ras_n) begin
      rlo_n++;
      if (!lcas_n) cil_n++;
    end
    if (!p_ras && ras_n) begin
      chk(rlo_n == RLOW, "R4 ras width", rlo_n, RLOW);
      chk(cil_n == HOLD, "R4 cas hold", cil_n, HOLD);
      chk(lcas_n, "R4 cas high at ras rise", lcas_n, 1);
      n_rises++; rhi_n = 0; lead_n = 0;
    end
    if (ras_n) rhi_n++;
    if (!ras_n || !lcas_n) chk(lane_hiz, "R6 float", lane_hiz, 1);
    if (n_rises < WARM) chk(!ready, "R2 early ready", ready, 0);
    if (!p_rdy && ready) begin
      chk(n_rises == WARM, "R2 warm count", n_rises, WARM);
      rdy_at = cyc;
    end
    if (p_rdy) chk(ready, "R2 sticky", ready, 1);
    if (ready && rdy_at >= 0) begin
      ticks = (cyc - rdy_at) / exp_interval();
      debt  = ticks - starts;
      chk(ref_urgent == (debt >= MAXD), "R9 urgent", ref_urgent, debt);
      chk(ref_req == (!lane_hiz && debt > 0), "R7 request", ref_req, debt);
      if (ref_urgent) saw_urgent = 1;
    end else begin
      chk(!ref_req && !ref_urgent, "R7 no req before ready", {ref_req, ref_urgent}, 0);
    end
    chk(acc_gnt_o == (acc_gnt_i && ready && !lane_hiz && !ref_urgent && !(ref_req && ref_gnt)),
        "R10 access gate", acc_gnt_o, acc_gnt_i);
    p_ras = ras_n; p_cas = lcas_n; p_rdy = ready; p_urg = ref_urgent;
    p_req = ref_req; p_gnt = ref_gnt;
  endtask

  // mode 0 random, 1 no grant, 2 always grant
  task automatic step(input int mode);
    @(posedge clk);
    #1;
    case (mode)
      1:       ref_gnt = 1'b0;
      2:       ref_gnt = 1'b1;
      default: ref_gnt = 1'($urandom % 2);
    endcase
    acc_gnt_i = ($urandom % 4) != 0;
    #1.5;
    monitor();
  endtask

  initial begin
    int s0, s1;
    void'($urandom(32'd4711));
    rst_n = 1'b0; ref_gnt = 1'b0; acc_gnt_i = 1'b1;
    repeat (4) @(posedge clk);
    #2.5;
    chk(!ready && ras_n && lcas_n && ucas_n && !ref_req && !acc_gnt_o && !lane_hiz,
        "R1 reset state", {ready, ras_n, lcas_n, ref_req, acc_gnt_o, lane_hiz}, 6'b011000);
    @(posedge clk); #1;
    rst_n = 1'b1;
    #1.5;
    // power-up: grants offered randomly, must be irrelevant
    for (int i = 0; i < PAUSE + 400 && !ready; i++) step(0);
    chk(ready, "R2 ready reached", ready, 1);
    for (int i = 0; i < 12000; i++) step(0);
    // directed: grant withheld, debt must hit the limit and force refreshes
    s0 = starts;
    for (int i = 0; i < 40 * exp_interval(); i++) step(1);
    s1 = starts;
    chk(saw_urgent, "R9 urgent seen", saw_urgent, 1);
    chk(s1 - s0 >= 40 - MAXD - 1, "R8 forced refreshes", s1 - s0, 40 - MAXD - 1);
    for (int i = 0; i < 2000; i++) step(2);
    for (int i = 0; i < 12000; i++) step(0);
    // retention window
    chk(ts.size() >= (cyc - rdy_at) / exp_interval() - MAXD, "R11 total",
        ts.size(), (cyc - rdy_at) / exp_interval() - MAXD);
    for (int k = 0; k + ROWS - 1 < ts.size(); k++) begin
      longint base;
      base = (k == 0) ? rdy_at : ts[k-1];
      chk(ts[k+ROWS-1] - base <= RET, "R11 window", ts[k+ROWS-1] - base, RET);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule